// File: doc/BRIEF.md
# Interval Timer Host Access Controller

This block is the byte-wide host register front end of a three-channel interval timer. A two-bit address picks one of three channel data ports or a write-only control port. For each channel the block keeps an access mode, an operating mode and a decimal flag. It also runs the low/high byte sequencing for data writes and data reads. The counting itself happens in separate per-channel engines. Each engine supplies its live 16-bit count and its output level to this block. In return, the block sends the engine a one-cycle load strobe and the assembled 16-bit start value.

The host can freeze a channel's count with a latch command. It can also issue a read-back command, which captures the count, a status byte, or both, for any subset of channels at once. A data read follows a fixed priority: pending status first, then latched count bytes, then live count bytes.

Top module: `pit_host_if`

## Requirements
- R1: Addresses 0, 1 and 2 reach the data ports of channels 0, 1 and 2. Address 3 is the control port. A read of address 3 returns 8'h00.
- R2: A control byte carries the channel in bits 7:6, the access mode in bits 5:4 (0 latch, 1 low byte only, 2 high byte only, 3 low then high), the operating mode in bits 3:1 and the decimal flag in bit 0. A channel value of 3 marks a read-back command. A control write changes only the selected channel and never pulses a load.
- R3: A control byte with a non-zero access mode returns both the write sequence and the read sequence of that channel to the low byte.
- R4: A data write pulses exactly one bit of load_strobe, the bit of the addressed channel, in the cycle after the write. The load value is {8'h00,byte} in mode 1 and {byte,8'h00} in mode 2. In mode 3 the first byte is held without a load, and the second byte loads {second,first}.
- R5: With no latch or status pending, a data read returns a byte of the live count: the low byte in mode 1, the high byte in mode 2, and alternately low then high in mode 3.
- R6: A latch request captures the live count of its channel. While that channel still holds a latched count that has not been fully read, further latch requests leave the latched count unchanged.
- R7: A latched count is released after one read in mode 1 (low byte) or mode 2 (high byte). In mode 3 it is released after two reads, low byte first.
- R8: In a read-back command, bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 at 0 requests a count latch and bit 4 at 0 requests a status latch. A status request is ignored while earlier status is still pending on that channel.
- R9: The status byte is {output level, 1'b0, access mode[1:0], operating mode[2:0], decimal flag}.
- R10: A data read returns pending status first and clears it. Otherwise it returns latched count bytes. Only when neither is pending does it return live count bytes.
- R11: After reset, rdata and load_strobe are 0 and every channel's access mode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 2 | Port select: 0..2 data ports, 3 control port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, registered, updated on each read |
| live_count | input | 48 | Live counts of the three channels, channel 0 in bits 15:0 |
| out_level | input | 3 | Output levels of the three channels |
| load_strobe | output | 3 | One-cycle load pulse per channel |
| load_value | output | 16 | 16-bit value that goes with the load pulse |

## Verification
Every result of this block appears exactly one rising edge after the access that causes it. The read byte is registered on the edge that samples rd_en, and load_strobe and load_value are registered on the edge that samples the completing write. The bench drives each access at a falling edge and holds it for one rising edge. It reads rdata and the load outputs at the next falling edge, which is the only cycle in which the one-cycle load pulse is visible. Side effects of a read, such as a released latch, a cleared status or an advanced byte sequence, are checked through the byte that the following read returns.

// File: rtl/pit_host_pkg.sv
package pit_host_pkg;
  localparam int NUM_CH = 3;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic [1:0] chan;
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } ctrl_word_t;

  function automatic logic [BYTE_W-1:0] status_byte(input logic out_lvl, input logic [1:0] acc,
                                                    input logic [2:0] mode, input logic bcd);
    return {out_lvl, 1'b0, acc, mode, bcd};
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [CNT_W-1:0] cnt, input logic hi);
    return hi ? cnt[CNT_W-1:BYTE_W] : cnt[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/pit_cmd_decode.sv
module pit_cmd_decode
  import pit_host_pkg::*;
(
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [BYTE_W-1:0]     wdata,
  output logic [NUM_CH-1:0]     cfg_we,
  output acc_e                  cfg_acc,
  output logic [2:0]            cfg_mode,
  output logic                  cfg_bcd,
  output logic [NUM_CH-1:0]     latch_req,
  output logic [NUM_CH-1:0]     stat_req,
  output logic [NUM_CH-1:0]     data_we,
  output logic [NUM_CH-1:0]     data_re
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CH);

  ctrl_word_t cw;
  logic       ctrl_wr;
  logic       is_rb;

  assign cw       = ctrl_word_t'(wdata);
  assign ctrl_wr  = wr_en && (addr == CTRL_ADDR);
  assign is_rb    = (cw.chan == 2'd3);
  assign cfg_acc  = cw.acc;
  assign cfg_mode = cw.mode;
  assign cfg_bcd  = cw.bcd;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    logic sel;
    logic rb_sel;
    assign sel          = !is_rb && (cw.chan == 2'(c));
    assign rb_sel       = is_rb && wdata[c+1];
    assign cfg_we[c]    = ctrl_wr && sel && (cw.acc != ACC_LATCH);
    assign latch_req[c] = ctrl_wr && ((sel && cw.acc == ACC_LATCH) || (rb_sel && !wdata[5]));
    assign stat_req[c]  = ctrl_wr && rb_sel && !wdata[4];
    assign data_we[c]   = wr_en && (addr == ADDR_W'(c));
    assign data_re[c]   = rd_en && (addr == ADDR_W'(c));
  end
endmodule

// File: rtl/pit_chan_regs.sv
module pit_chan_regs
  import pit_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  acc_e              cfg_acc,
  input  logic [2:0]        cfg_mode,
  input  logic              cfg_bcd,
  input  logic              latch_req,
  input  logic              stat_req,
  input  logic              data_we,
  input  logic              data_re,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live_count,
  input  logic              out_level,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              load_fire,
  output logic [CNT_W-1:0]  load_val,
  output logic              lat_busy,
  output logic              stat_pend,
  output logic [CNT_W-1:0]  lat_cnt
);
  acc_e              acc;
  logic [2:0]        mode;
  logic              bcd;
  logic              wr_tog;
  logic              rd_tog;
  logic [BYTE_W-1:0] hold;
  logic [1:0]        lat_st;
  logic [BYTE_W-1:0] stat_q;

  assign lat_busy = (lat_st != 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= ACC_LATCH;
      mode      <= '0;
      bcd       <= 1'b0;
      wr_tog    <= 1'b0;
      rd_tog    <= 1'b0;
      hold      <= '0;
      lat_st    <= '0;
      lat_cnt   <= '0;
      stat_pend <= 1'b0;
      stat_q    <= '0;
    end else begin
      if (data_we && acc == ACC_WORD) begin
        if (!wr_tog) hold <= wdata;
        wr_tog <= !wr_tog;
      end
      if (latch_req && !lat_busy) begin
        lat_cnt <= live_count;
        lat_st  <= acc;
      end
      if (stat_req && !stat_pend) begin
        stat_pend <= 1'b1;
        stat_q    <= status_byte(out_level, acc, mode, bcd);
      end
      if (data_re) begin
        if (stat_pend) stat_pend <= 1'b0;
        else if (lat_busy) lat_st <= (lat_st == ACC_WORD) ? 2'(ACC_HI) : 2'd0;
        else if (acc == ACC_WORD) rd_tog <= !rd_tog;
      end
      if (cfg_we) begin
        acc    <= cfg_acc;
        mode   <= cfg_mode;
        bcd    <= cfg_bcd;
        wr_tog <= 1'b0;
        rd_tog <= 1'b0;
      end
    end
  end

  always_comb begin
    if (stat_pend)              rd_byte = stat_q;
    else if (lat_st == ACC_HI)  rd_byte = pick_byte(lat_cnt, 1'b1);
    else if (lat_busy)          rd_byte = pick_byte(lat_cnt, 1'b0);
    else rd_byte = pick_byte(live_count, (acc == ACC_HI) || (acc == ACC_WORD && rd_tog));
  end

  assign load_fire = data_we && (acc != ACC_WORD || wr_tog);

  always_comb begin
    case (acc)
      ACC_HI:   load_val = {wdata, {BYTE_W{1'b0}}};
      ACC_WORD: load_val = {wdata, hold};
      default:  load_val = {{BYTE_W{1'b0}}, wdata};
    endcase
  end
endmodule

// File: rtl/pit_host_if.sv
module pit_host_if
  import pit_host_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [1:0]              addr,
  input  logic [7:0]              wdata,
  output logic [7:0]              rdata,
  input  logic [47:0]             live_count,
  input  logic [2:0]              out_level,
  output logic [2:0]              load_strobe,
  output logic [15:0]             load_value
);
  logic [NUM_CH-1:0]             cfg_we;
  acc_e                          cfg_acc;
  logic [2:0]                    cfg_mode;
  logic                          cfg_bcd;
  logic [NUM_CH-1:0]             latch_req;
  logic [NUM_CH-1:0]             stat_req;
  logic [NUM_CH-1:0]             data_we;
  logic [NUM_CH-1:0]             data_re;
  logic [NUM_CH-1:0][BYTE_W-1:0] rd_byte;
  logic [NUM_CH-1:0]             load_fire;
  logic [NUM_CH-1:0][CNT_W-1:0]  load_val;
  logic [NUM_CH-1:0]             lat_busy;
  logic [NUM_CH-1:0]             stat_pend;
  logic [NUM_CH-1:0][CNT_W-1:0]  lat_cnt;

  pit_cmd_decode u_dec (
    .wr_en, .rd_en, .addr, .wdata,
    .cfg_we, .cfg_acc, .cfg_mode, .cfg_bcd,
    .latch_req, .stat_req, .data_we, .data_re
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pit_chan_regs u_ch (
      .clk, .rst_n,
      .cfg_we     (cfg_we[c]),
      .cfg_acc,
      .cfg_mode,
      .cfg_bcd,
      .latch_req  (latch_req[c]),
      .stat_req   (stat_req[c]),
      .data_we    (data_we[c]),
      .data_re    (data_re[c]),
      .wdata,
      .live_count (live_count[c*CNT_W +: CNT_W]),
      .out_level  (out_level[c]),
      .rd_byte    (rd_byte[c]),
      .load_fire  (load_fire[c]),
      .load_val   (load_val[c]),
      .lat_busy   (lat_busy[c]),
      .stat_pend  (stat_pend[c]),
      .lat_cnt    (lat_cnt[c])
    );
  end

  logic [CNT_W-1:0] load_mux;
  always_comb begin
    load_mux = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (load_fire[c]) load_mux = load_val[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata       <= '0;
      load_strobe <= '0;
      load_value  <= '0;
    end else begin
      load_strobe <= load_fire;
      if (load_fire != '0) load_value <= load_mux;
      if (rd_en) rdata <= (addr == 2'd3) ? 8'h00 : rd_byte[addr];
    end
  end
endmodule

// File: rtl/pit_host_if_chk.sv
module pit_host_if_chk
  import pit_host_pkg::*;
(
  input logic                            clk,
  input logic                            rst_n,
  input logic                            rd_en,
  input logic                            wr_en,
  input logic [1:0]                      addr,
  input logic [7:0]                      rdata,
  input logic [2:0]                      load_strobe,
  input logic [NUM_CH-1:0]               latch_req,
  input logic [NUM_CH-1:0]               data_re,
  input logic [NUM_CH-1:0]               lat_busy,
  input logic [NUM_CH-1:0]               stat_pend,
  input logic [NUM_CH-1:0][CNT_W-1:0]    lat_cnt
);
  // R4
  load_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(load_strobe));

  // R1
  ctrl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd3) |=> (rdata == 8'h00));

  // R2
  ctrl_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3) |=> (load_strobe == 3'b000));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_busy[c] && latch_req[c] && !data_re[c]) |=> $stable(lat_cnt[c]));
    // R8
    stat_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_pend[c] && !data_re[c]) |=> stat_pend[c]);
    // R10
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_pend[c] && data_re[c]) |=> !stat_pend[c]);
  end
endmodule

bind pit_host_if pit_host_if_chk u_chk (.*);

// File: tb/sim_pit_host_if.sv
module sim_pit_host_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [47:0] live_count = '0;
  logic [2:0]  out_level = 3'b000;
  logic [2:0]  load_strobe;
  logic [15:0] load_value;

  int checks = 0;
  int errors = 0;
  logic [7:0] got;

  always #5 clk = ~clk;

  pit_host_if u0 (.*);

  function automatic logic [7:0] cw(input int ch, input int acc, input int mode, input int bcd);
    return {2'(ch), 2'(acc), 3'(mode), 1'(bcd)};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic set_live(input int ch, input logic [15:0] v);
    live_count[ch*16 +: 16] = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 rdata", {8'h0, rdata}, 16'h0);
    chk("R11 load_strobe", {13'h0, load_strobe}, 16'h0);

    // R4 R2 write sweep over channels and access modes
    for (int c = 0; c < 3; c++) begin
      for (int a = 1; a < 4; a++) begin
        logic [7:0] d0 = 8'(8'h30 + c * 16 + a);
        logic [7:0] d1 = ~d0;
        wr(2'd3, cw(c, a, a + 1, 0));
        chk("R2 ctrl no load", {13'h0, load_strobe}, 16'h0);
        wr(2'(c), d0);
        if (a == 3) begin
          chk("R4 first byte held", {13'h0, load_strobe}, 16'h0);
          wr(2'(c), d1);
          chk("R4 word strobe", {13'h0, load_strobe}, 16'(1 << c));
          chk("R4 word value", load_value, {d1, d0});
        end else begin
          chk("R4 byte strobe", {13'h0, load_strobe}, 16'(1 << c));
          chk("R4 byte value", load_value, (a == 1) ? {8'h00, d0} : {d0, 8'h00});
        end
      end
    end

    // R2 control for channel 0 leaves channel 1 in mode 2
    wr(2'd3, cw(1, 2, 0, 0));
    wr(2'd3, cw(0, 1, 0, 0));
    wr(2'd1, 8'h5A);
    chk("R2 other channel kept", load_value, 16'h5A00);

    // R5 live reads
    for (int c = 0; c < 3; c++) begin
      logic [15:0] v = 16'(16'h1234 + c * 16'h1111);
      set_live(c, v);
      for (int a = 1; a < 4; a++) begin
        wr(2'd3, cw(c, a, 0, 0));
        rd(2'(c), got);
        chk("R5 first live byte", {8'h0, got}, {8'h0, (a == 2) ? v[15:8] : v[7:0]});
        if (a == 3) begin
          rd(2'(c), got);
          chk("R5 second live byte", {8'h0, got}, {8'h0, v[15:8]});
          rd(2'(c), got);
          chk("R5 toggle wraps", {8'h0, got}, {8'h0, v[7:0]});
        end
      end
    end

    // R3 toggles restart on control write
    wr(2'd3, cw(0, 3, 0, 0));
    wr(2'd0, 8'h11);
    wr(2'd3, cw(0, 3, 0, 0));
    wr(2'd0, 8'h22);
    chk("R3 write restart no load", {13'h0, load_strobe}, 16'h0);
    wr(2'd0, 8'h33);
    chk("R3 write restart value", load_value, 16'h3322);
    set_live(0, 16'hA1B2);
    rd(2'd0, got);
    wr(2'd3, cw(0, 3, 0, 0));
    rd(2'd0, got);
    chk("R3 read restart", {8'h0, got}, 16'h00B2);

    // R1 control port reads zero
    rd(2'd3, got);
    chk("R1 ctrl read", {8'h0, got}, 16'h0);

    // R8 R9 status sweep via read-back
    for (int c = 0; c < 3; c++) wr(2'd3, cw(c, (c % 3) + 1, c + 2, c & 1));
    out_level = 3'b101;
    wr(2'd3, 8'hEE);
    for (int c = 0; c < 3; c++) begin
      rd(2'(c), got);
      chk("R9 status byte", {8'h0, got},
          {8'h0, out_level[c], 1'b0, 2'((c % 3) + 1), 3'(c + 2), 1'(c & 1)});
    end
    // R8 status not relatched while pending
    set_live(0, 16'h4455);
    wr(2'd3, 8'hE2);
    out_level = 3'b010;
    wr(2'd3, 8'hE2);
    rd(2'd0, got);
    chk("R8 status kept", {8'h0, got}, {8'h0, 8'b1_0_01_010_0});
    rd(2'd0, got);
    chk("R10 status cleared then live", {8'h0, got}, 16'h0055);

    // R6 R7 counter latch in two-byte mode
    wr(2'd3, cw(1, 3, 0, 0));
    set_live(1, 16'hBEEF);
    wr(2'd3, cw(1, 0, 0, 0));
    set_live(1, 16'h1357);
    rd(2'd1, got);
    chk("R7 latched low", {8'h0, got}, 16'h00EF);
    wr(2'd3, cw(1, 0, 0, 0));
    rd(2'd1, got);
    chk("R6 relatch ignored", {8'h0, got}, 16'h00BE);
    rd(2'd1, got);
    chk("R7 released live low", {8'h0, got}, 16'h0057);
    rd(2'd1, got);
    chk("R5 live high", {8'h0, got}, 16'h0013);

    // R7 single-byte latch release
    wr(2'd3, cw(1, 2, 0, 0));
    set_live(1, 16'h7788);
    wr(2'd3, cw(1, 0, 0, 0));
    set_live(1, 16'h99AA);
    rd(2'd1, got);
    chk("R7 latched high", {8'h0, got}, 16'h0077);
    rd(2'd1, got);
    chk("R7 single release", {8'h0, got}, 16'h0099);

    // R10 priority with status and count latched by read-back
    wr(2'd3, 8'hB4);
    set_live(2, 16'hCAFE);
    out_level = 3'b100;
    wr(2'd3, 8'hC8);
    set_live(2, 16'h0000);
    rd(2'd2, got);
    chk("R10 status first", {8'h0, got}, 16'h00B4);
    rd(2'd2, got);
    chk("R10 latch low second", {8'h0, got}, 16'h00FE);
    rd(2'd2, got);
    chk("R10 latch high third", {8'h0, got}, 16'h00CA);
    rd(2'd2, got);
    chk("R10 live last", {8'h0, got}, 16'h0000);

    // R8 read-back selecting only channel 0 count leaves channel 1 live
    wr(2'd3, cw(1, 1, 0, 0));
    set_live(0, 16'h0F0E);
    set_live(1, 16'h2021);
    wr(2'd3, 8'hD2);
    set_live(0, 16'h0000);
    set_live(1, 16'h3031);
    rd(2'd1, got);
    chk("R8 unselected live", {8'h0, got}, 16'h0031);
    rd(2'd0, got);
    chk("R8 selected latched", {8'h0, got}, 16'h000E);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule